// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of equal width WIDTH and returns their full signed product of 2*WIDTH bits. It works one recoded bit position per clock. Each operand is widened to 2*WIDTH bits by sign extension when it is captured. The multiplier is then scanned pair by pair, where each pair is a bit together with the bit below it. Depending on the pair, the multiplicand aligned to that bit position is added to the accumulator, subtracted from it, or skipped.

A request is a single-cycle pulse on `start_i` with both operands present. The block raises `busy_o` while it works and pulses `done_o` once the product is ready. The product then stays on `product_o` until the next accepted request.

Top module: `booth_seq_mult`

## Requirements
- R1: While `rst` is high at a rising edge, the block clears itself, so that after that edge `busy_o`, `done_o` and `product_o` are all zero.
- R2: A high `start_i` seen at a rising edge while `busy_o` is low captures both operands, clears the accumulator and sets `busy_o` from that edge on.
- R3: When `done_o` is high, `product_o` equals the signed product of the captured operands as a 2*WIDTH-bit two's-complement value.
- R4: `busy_o` stays high for exactly 2*WIDTH cycles after the accepting edge. `done_o` is then high for exactly one cycle, with `busy_o` low.
- R5: `start_i` and operand changes while `busy_o` is high have no effect on the result or on the timing of the request in progress.
- R6: After `done_o`, `product_o` holds its value until another request is accepted.
- R7: At each position i, the pair (multiplier bit i, bit i-1) selects the action. Pair 01 adds the multiplicand shifted left by i. Pair 10 adds the bitwise inverse plus one of that shifted value. Pairs 00 and 11 leave the accumulator unchanged.
- R8: Position 0 is recoded against an implicit zero below the multiplier LSB, so odd multipliers give correct products.
- R9: The most negative operand values give correct results, for example -2^(WIDTH-1) times -2^(WIDTH-1) equals 2^(2*WIDTH-2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request pulse; accepted only while idle |
| mcand_i | input | WIDTH | Signed multiplicand |
| mplier_i | input | WIDTH | Signed multiplier |
| busy_o | output | 1 | High while positions are being consumed |
| done_o | output | 1 | One-cycle pulse when the product is ready |
| product_o | output | 2*WIDTH | Signed product, held after done |

## Verification
Small mixed-sign operands show whether sign extension is applied to each operand. A multiplier of 1 shows whether the implicit zero below bit 0 is present. A multiplier of -1 gives a single subtraction at position 0, and the alternating 0x55/0xAA patterns force an add or subtract at every low position; together they show whether the add and subtract actions were swapped or misaligned. The pairings of the most negative value with itself and with the most positive value test the top product bits. Pseudo-random pairs cover the remaining mixes, and some of them carry a second start pulse during busy, which shows whether a restart is wrongly accepted.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;

  // Radix-2 recoding of one position: current bit and the bit below it.
  function automatic booth_op_e pair_op(input logic cur, input logic below);
    case ({cur, below})
      2'b01:   return OP_ADD;
      2'b10:   return OP_SUB;
      default: return OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int POS_COUNT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic load_o,
  output logic step_o
);
  localparam int CW = (POS_COUNT > 2) ? $clog2(POS_COUNT) : 1;

  logic [CW-1:0] pos_q;
  logic          last_w;

  assign load_o = start_i && !busy_o;
  assign step_o = busy_o;
  assign last_w = step_o && (pos_q == CW'(POS_COUNT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      pos_q  <= '0;
    end else begin
      done_o <= last_w;
      if (load_o) begin
        busy_o <= 1'b1;
        pos_q  <= '0;
      end else if (step_o) begin
        pos_q <= pos_q + 1'b1;
        if (last_w) busy_o <= 1'b0;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R4
  AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !last_w) |=> (busy_o && pos_q == $past(pos_q) + 1'b1)); // R5

endmodule

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] mplier_i,
  output booth_op_e        op_o
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0] mreg_q;
  logic          below_q;  // bit i-1; zero before position 0

  always_ff @(posedge clk) begin
    if (load_i) begin
      mreg_q  <= {{WIDTH{mplier_i[WIDTH-1]}}, mplier_i};
      below_q <= 1'b0;
    end else if (step_i) begin
      mreg_q  <= mreg_q >> 1;
      below_q <= mreg_q[0];
    end
  end

  assign op_o = pair_op(mreg_q[0], below_q);

endmodule

// File: rtl/booth_accum.sv
module booth_accum
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              step_i,
  input  booth_op_e         op_i,
  input  logic [WIDTH-1:0]  mcand_i,
  output logic [2*WIDTH-1:0] acc_o
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0] mc_q;   // multiplicand aligned to the current position
  logic [PW-1:0] acc_q;

  function automatic logic [PW-1:0] negate(input logic [PW-1:0] x);
    return ~x + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (load_i)      mc_q <= {{WIDTH{mcand_i[WIDTH-1]}}, mcand_i};
    else if (step_i) mc_q <= mc_q << 1;
  end

  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      acc_q <= '0;
    end else if (step_i) begin
      case (op_i)
        OP_ADD:  acc_q <= acc_q + mc_q;
        OP_SUB:  acc_q <= acc_q + negate(mc_q);
        default: acc_q <= acc_q;
      endcase
    end
  end

  assign acc_o = acc_q;

  AST_CLEAR_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (acc_q == '0)); // R2
  AST_NONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (step_i && op_i == OP_NONE) |=> $stable(acc_q)); // R7

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  localparam int PW = 2 * WIDTH;

  logic      load_w;
  logic      step_w;
  booth_op_e op_w;

  booth_ctrl #(.POS_COUNT(PW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .load_o  (load_w),
    .step_o  (step_w)
  );

  booth_recode #(.WIDTH(WIDTH)) u_recode (
    .clk      (clk),
    .load_i   (load_w),
    .step_i   (step_w),
    .mplier_i (mplier_i),
    .op_o     (op_w)
  );

  booth_accum #(.WIDTH(WIDTH)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load_w),
    .step_i  (step_w),
    .op_i    (op_w),
    .mcand_i (mcand_i),
    .acc_o   (product_o)
  );

  AST_PRODUCT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> $stable(product_o)); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R4

endmodule

// File: tb/sim_booth_seq_mult.sv
module sim_booth_seq_mult;
  localparam int W  = 8;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [W-1:0]  mcand_i = '0;
  logic [W-1:0]  mplier_i = '0;
  logic          busy_o, done_o;
  logic [PW-1:0] product_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [PW-1:0] sb_q[$];

  always #10 clk = ~clk;  // 50 MHz

  booth_seq_mult #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .mcand_i(mcand_i),
    .mplier_i(mplier_i), .busy_o(busy_o), .done_o(done_o), .product_o(product_o)
  );

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cycles);
      finish_run();
    end
  end

  // Monitor: compares each done pulse against the scoreboard (R3)
  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (sb_q.size() == 0) begin
        check("R3 unexpected done", 1, 0);
      end else begin
        check("R3 product", product_o, sb_q.pop_front());
      end
    end
  end

  // Driver: pushes expected product, issues request, checks timing
  task automatic run_vec(input logic signed [W-1:0] a, input logic signed [W-1:0] b,
                         input bit poke, input string tag);
    int ea = a;
    int eb = b;
    int p  = ea * eb;
    logic [PW-1:0] exp = p[PW-1:0];
    int c;
    sb_q.push_back(exp);
    @(negedge clk);
    start_i = 1'b1; mcand_i = a; mplier_i = b;
    @(negedge clk);
    start_i = 1'b0; mcand_i = ~a; mplier_i = ~b;
    check({"R2 busy after start ", tag}, PW'(busy_o), PW'(1));
    c = 1;
    while (!done_o && c < 1000) begin
      @(negedge clk);
      c++;
      if (poke && c == 3) begin
        start_i = 1'b1; mcand_i = 8'h5b; mplier_i = 8'hc3;  // R5 ignored while busy
      end else begin
        start_i = 1'b0;
      end
    end
    check({"R4 latency ", tag}, PW'(c), PW'(PW + 1));
    check({"R4 busy low at done ", tag}, PW'(busy_o), PW'(0));
    @(negedge clk);
    check({"R4 done one cycle ", tag}, PW'(done_o), PW'(0));
    check({"R6 product held ", tag}, product_o, exp);
    @(negedge clk);
    @(negedge clk);
    check({"R6 product held later ", tag}, product_o, exp);
  endtask

  initial begin
    int unsigned seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", PW'(busy_o), PW'(0));
    check("R1 done in reset", PW'(done_o), PW'(0));
    check("R1 product in reset", product_o, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", PW'(busy_o), PW'(0));

    run_vec(8'sd3,    8'sd5,    1'b0, "R3 small");
    run_vec(-8'sd7,   8'sd6,    1'b0, "R3 mixed sign");
    run_vec(8'sd9,    -8'sd11,  1'b0, "R3 neg multiplier");
    run_vec(8'sd77,   8'sd1,    1'b0, "R8 lsb set");
    run_vec(-8'sd45,  8'sd3,    1'b0, "R8 odd multiplier");
    run_vec(8'sd13,   -8'sd1,   1'b0, "R7 all ones");
    run_vec(8'sd85,   8'sd85,   1'b0, "R7 alternating 55");
    run_vec(-8'sd86,  -8'sd86,  1'b0, "R7 alternating AA");
    run_vec(-8'sd128, -8'sd128, 1'b0, "R9 min times min");
    run_vec(-8'sd128, 8'sd127,  1'b0, "R9 min times max");
    run_vec(8'sd127,  -8'sd128, 1'b0, "R9 max times min");
    run_vec(8'sd0,    -8'sd55,  1'b0, "R3 zero");
    run_vec(8'sd21,   8'sd19,   1'b1, "R5 poke");
    for (int i = 0; i < 40; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      run_vec(seed[23:16], seed[31:24], (i % 3) == 0, "R3 random");
    end
    @(negedge clk);
    check("R3 scoreboard drained", PW'(sb_q.size()), PW'(0));
    finish_run();
  end

endmodule